// File: doc/BRIEF.md
# Variable-Length Frame Header Parser

This block sits on the receive byte stream just after the demodulator and byte aligner. At the start of each frame it reads the physical header, extracts the frame length and then counts the bytes that follow so that downstream logic receives a strobe on the final byte of the frame. The length value covers the whole remainder of the frame, including the CRC bytes, and no offset is added to it.

Two header formats are supported, and a format-select input chooses between them. The short format is a single byte that carries a 7-bit length. The long format is two bytes that carry an 11-bit length together with a CRC-type flag and a whitening flag. These flags are passed on so that the CRC checker and the de-whitener can be configured for the frame. Each byte's bit 0 is the first bit received. Every field is read in that order except the long-format length, which is sent most significant bit first.

A length above the limit for the selected format is reported on a one-cycle error strobe. The frame is then dropped, and the next byte is treated as a new header. All outputs are registered, and every strobe appears in the cycle after the byte that causes it.

Top module: `phr_frame_parser`

## Requirements
- R1: While `rst` is high and after it is released, `hdr_done`, `last_byte`, `len_err`, `len_out`, `fcs_flag` and `wht_flag` are all 0, and the next accepted byte is taken as the first header byte.
- R2: Short format (`fmt_long`=0 on the first header byte): the length is `in_byte[6:0]` and bit 7 is ignored. In the cycle after that byte, `hdr_done` pulses, `len_out` holds the length, and both flags read 0.
- R3: Long format (`fmt_long`=1 on the first header byte): no strobe follows the first byte. The length is assembled MSB first: len[10]=byte0[5], len[9]=byte0[6], len[8]=byte0[7], and len[7-k]=byte1[k] for k=0..7. Bits 0 to 2 of byte0 are ignored. `hdr_done` pulses in the cycle after byte1.
- R4: In the long format, `fcs_flag` takes byte0[3] and `wht_flag` takes byte0[4] when `hdr_done` pulses. Both flags hold their values until the next header is accepted.
- R5: After a header of length N>0, exactly N more bytes belong to the frame. `last_byte` pulses in the cycle after the N-th byte, and no strobe appears for the earlier bytes.
- R6: A zero length raises `hdr_done` and `last_byte` in the same cycle, and the byte after the header is parsed as a new header.
- R7: A length above SHORT_MAX (short format) or LONG_MAX (long format) gives a one-cycle `len_err` with `len_out` holding that length and neither `hdr_done` nor `last_byte`. The next byte is parsed as a new header.
- R8: `fmt_long` is sampled only on the first header byte of a frame. Its value on the second header byte and on payload bytes has no effect.
- R9: Cycles with `in_valid` low consume no byte and produce no strobe.
- R10: Frames may follow each other with no idle cycles between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_byte` carries a received byte this cycle |
| in_byte | input | 8 | Received byte, bit 0 received first |
| fmt_long | input | 1 | 1 selects the two-byte header, 0 the one-byte header |
| len_out | output | 11 | Decoded frame length, including CRC bytes |
| fcs_flag | output | 1 | CRC-type flag from the long header |
| wht_flag | output | 1 | Whitening flag from the long header |
| hdr_done | output | 1 | One-cycle strobe: a valid header was accepted |
| last_byte | output | 1 | One-cycle strobe: final byte of the frame |
| len_err | output | 1 | One-cycle strobe: the length exceeds the format limit, and the frame is dropped |

## Verification
The bench builds the parser with SHORT_MAX=100 and LONG_MAX=300 instead of the full 127 and 2047. With the defaults, no 7-bit or 11-bit field could exceed its limit, so the error path in either format would be out of reach. These values also put the exact boundary lengths (100/101 and 300/301) next to each other, so the comparison is tested on both sides of each limit. A long frame of 300 bytes with stalls exercises the counter across the full 9-bit span of values used.

// File: rtl/phr_pkg.sv
package phr_pkg;
  localparam int LEN_W   = 11;
  localparam int BYTE_W  = 8;
  localparam int SHORT_W = 7;

  typedef enum logic [1:0] {
    ST_HDR0 = 2'd0,
    ST_HDR1 = 2'd1,
    ST_BODY = 2'd2
  } parse_st_e;

  function automatic logic [BYTE_W-1:0] rev_byte(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/phr_hdr_decode.sv
module phr_hdr_decode
  import phr_pkg::*;
#(
  parameter int SHORT_MAX = 127,
  parameter int LONG_MAX  = 2047
) (
  input  logic              fmt_long,
  input  logic [BYTE_W-1:0] b0,
  input  logic [BYTE_W-1:0] b1,
  output logic [LEN_W-1:0]  len_o,
  output logic              fcs_o,
  output logic              wht_o,
  output logic              over_o
);
  localparam logic [LEN_W-1:0] SHORT_LIM = SHORT_MAX[LEN_W-1:0];
  localparam logic [LEN_W-1:0] LONG_LIM  = LONG_MAX[LEN_W-1:0];

  always_comb begin
    if (fmt_long) begin
      // first length bit on the line (byte0 bit 5) is the MSB
      len_o  = {b0[5], b0[6], b0[7], rev_byte(b1)};
      fcs_o  = b0[3];
      wht_o  = b0[4];
      over_o = (len_o > LONG_LIM);
    end else begin
      len_o  = {{(LEN_W-SHORT_W){1'b0}}, b0[SHORT_W-1:0]};
      fcs_o  = 1'b0;
      wht_o  = 1'b0;
      over_o = (len_o > SHORT_LIM);
    end
  end
endmodule

// File: rtl/phr_len_counter.sv
module phr_len_counter
  import phr_pkg::*;
#(
  parameter int CNT_W = LEN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             is_one
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst)       remain_q <= '0;
    else if (load) remain_q <= load_val;
    else if (dec)  remain_q <= remain_q - 1'b1;
  end

  assign is_one = (remain_q == {{(CNT_W-1){1'b0}}, 1'b1});

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    dec |-> (remain_q != '0));

  p_load_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val != '0));
endmodule

// File: rtl/phr_frame_parser.sv
module phr_frame_parser
  import phr_pkg::*;
#(
  parameter int SHORT_MAX = 127,
  parameter int LONG_MAX  = 2047
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              fmt_long,
  output logic [LEN_W-1:0]  len_out,
  output logic              fcs_flag,
  output logic              wht_flag,
  output logic              hdr_done,
  output logic              last_byte,
  output logic              len_err
);
  localparam logic [LEN_W-1:0] SHORT_LIM = SHORT_MAX[LEN_W-1:0];
  localparam logic [LEN_W-1:0] LONG_LIM  = LONG_MAX[LEN_W-1:0];

  parse_st_e         state_q;
  logic [BYTE_W-1:0] b0_q;
  logic              fmt_q;

  logic              dec_fmt;
  logic [BYTE_W-1:0] dec_b0;
  logic [LEN_W-1:0]  dec_len;
  logic              dec_fcs, dec_wht, dec_over;
  logic              hdr_complete, cnt_load, cnt_dec, cnt_one;

  // the format is latched on the first header byte only
  assign dec_fmt = (state_q == ST_HDR0) ? fmt_long : fmt_q;
  assign dec_b0  = (state_q == ST_HDR0) ? in_byte  : b0_q;

  assign hdr_complete = in_valid &&
                        (((state_q == ST_HDR0) && !fmt_long) || (state_q == ST_HDR1));

  phr_hdr_decode #(.SHORT_MAX(SHORT_MAX), .LONG_MAX(LONG_MAX)) u_dec (
    .fmt_long (dec_fmt),
    .b0       (dec_b0),
    .b1       (in_byte),
    .len_o    (dec_len),
    .fcs_o    (dec_fcs),
    .wht_o    (dec_wht),
    .over_o   (dec_over)
  );

  assign cnt_load = hdr_complete && !dec_over && (dec_len != '0);
  assign cnt_dec  = in_valid && (state_q == ST_BODY);

  phr_len_counter #(.CNT_W(LEN_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (dec_len),
    .dec      (cnt_dec),
    .is_one   (cnt_one)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_HDR0;
      b0_q      <= '0;
      fmt_q     <= 1'b0;
      len_out   <= '0;
      fcs_flag  <= 1'b0;
      wht_flag  <= 1'b0;
      hdr_done  <= 1'b0;
      last_byte <= 1'b0;
      len_err   <= 1'b0;
    end else begin
      hdr_done  <= 1'b0;
      last_byte <= 1'b0;
      len_err   <= 1'b0;
      if (hdr_complete) begin
        len_out <= dec_len;
        fmt_q   <= dec_fmt;
        if (dec_over) begin
          len_err <= 1'b1;
          state_q <= ST_HDR0;
        end else begin
          hdr_done <= 1'b1;
          fcs_flag <= dec_fcs;
          wht_flag <= dec_wht;
          if (dec_len == '0) begin
            last_byte <= 1'b1;
            state_q   <= ST_HDR0;
          end else begin
            state_q   <= ST_BODY;
          end
        end
      end else if (in_valid) begin
        case (state_q)
          ST_HDR0: begin
            b0_q    <= in_byte;
            fmt_q   <= 1'b1;
            state_q <= ST_HDR1;
          end
          ST_BODY: begin
            if (cnt_one) begin
              last_byte <= 1'b1;
              state_q   <= ST_HDR0;
            end
          end
          default: state_q <= ST_HDR0;
        endcase
      end
    end
  end

  p_done_err_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(hdr_done && len_err));

  p_err_range_r7: assert property (@(posedge clk) disable iff (rst)
    len_err |-> (len_out > (fmt_q ? LONG_LIM : SHORT_LIM)));

  p_zero_len_r6: assert property (@(posedge clk) disable iff (rst)
    (hdr_done && (len_out == '0)) |-> last_byte);

  p_short_fields_r2: assert property (@(posedge clk) disable iff (rst)
    (hdr_done && !fmt_q) |-> (!fcs_flag && !wht_flag && (len_out <= SHORT_LIM)));

  p_stall_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> (!hdr_done && !last_byte && !len_err));

  p_last_from_body_r5: assert property (@(posedge clk) disable iff (rst)
    (last_byte && !hdr_done) |-> $past(state_q == ST_BODY));
endmodule

// File: tb/phr_frame_parser_test.sv
module phr_frame_parser_test;
  localparam int SMAX = 100;
  localparam int LMAX = 300;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        fmt_long = 1'b0;
  logic [10:0] len_out;
  logic        fcs_flag, wht_flag, hdr_done, last_byte, len_err;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  phr_frame_parser #(.SHORT_MAX(SMAX), .LONG_MAX(LMAX)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .fmt_long(fmt_long), .len_out(len_out), .fcs_flag(fcs_flag),
    .wht_flag(wht_flag), .hdr_done(hdr_done), .last_byte(last_byte),
    .len_err(len_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic f);
    in_byte  = b;
    fmt_long = f;
    in_valid = 1'b1;
    @(posedge clk);
    #2;
    in_valid = 1'b0;
  endtask

  task automatic stall(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #2;
      check(!hdr_done && !last_byte && !len_err, "R9", "strobe during stall",
            {hdr_done, last_byte, len_err}, 0);
    end
  endtask

  function automatic logic [15:0] mk_long(input int len, input bit fcs,
                                          input bit wht, input logic [2:0] low);
    logic [10:0] l;
    logic [7:0]  b0, b1;
    l  = len[10:0];
    b0 = {l[8], l[9], l[10], wht, fcs, low};
    for (int k = 0; k < 8; k++) b1[k] = l[7-k];
    return {b1, b0};
  endfunction

  // payload bytes; fmt toggles to show it is ignored (R8)
  task automatic payload(input int len, input bit gaps);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 37 == 5)) stall(2);
      push(8'(i * 7 + 3), i[0]);
      check(last_byte == (i == len - 1), "R5", "last_byte on payload",
            last_byte, (i == len - 1));
      check(!hdr_done && !len_err, "R8", "header strobe in payload",
            {hdr_done, len_err}, 0);
    end
  endtask

  task automatic t_reset;
    check({hdr_done, last_byte, len_err, fcs_flag, wht_flag} == 0 && len_out == 0,
          "R1", "outputs after reset", int'(len_out), 0);
  endtask

  task automatic t_short(input int len, input bit b7);
    push({b7, len[6:0]}, 1'b0);
    check(hdr_done == 1'b1, "R2", "hdr_done short", hdr_done, 1);
    check(int'(len_out) == len, "R2", "len_out short", int'(len_out), len);
    check(!fcs_flag && !wht_flag, "R2", "flags short", {fcs_flag, wht_flag}, 0);
    check(last_byte == (len == 0), "R6", "last with header", last_byte, (len == 0));
    payload(len, 1'b0);
  endtask

  task automatic t_long(input int len, input bit fcs, input bit wht,
                        input logic [2:0] low, input bit gaps, input bit f2);
    logic [15:0] h;
    h = mk_long(len, fcs, wht, low);
    push(h[7:0], 1'b1);
    check(!hdr_done && !last_byte && !len_err, "R3", "no strobe after byte0",
          {hdr_done, last_byte, len_err}, 0);
    if (gaps) stall(3);
    push(h[15:8], f2);
    check(hdr_done == 1'b1, "R3", "hdr_done long", hdr_done, 1);
    check(int'(len_out) == len, "R3", "len_out long", int'(len_out), len);
    check(fcs_flag == fcs, "R4", "fcs_flag", fcs_flag, fcs);
    check(wht_flag == wht, "R4", "wht_flag", wht_flag, wht);
    check(last_byte == (len == 0), "R6", "last with header", last_byte, (len == 0));
    payload(len, gaps);
    check(fcs_flag == fcs && wht_flag == wht, "R4", "flags held to frame end",
          {fcs_flag, wht_flag}, {fcs, wht});
  endtask

  task automatic t_err_short(input int len);
    push({1'b0, len[6:0]}, 1'b0);
    check(len_err == 1'b1, "R7", "len_err short", len_err, 1);
    check(!hdr_done && !last_byte, "R7", "no done on error", {hdr_done, last_byte}, 0);
    check(int'(len_out) == len, "R7", "len_out on error", int'(len_out), len);
  endtask

  task automatic t_err_long(input int len);
    logic [15:0] h;
    h = mk_long(len, 1'b1, 1'b1, 3'b000);
    push(h[7:0], 1'b1);
    push(h[15:8], 1'b1);
    check(len_err == 1'b1, "R7", "len_err long", len_err, 1);
    check(!hdr_done && !last_byte, "R7", "no done on error", {hdr_done, last_byte}, 0);
    check(int'(len_out) == len, "R7", "len_out on error", int'(len_out), len);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst = 1'b0;
    @(posedge clk);
    #2;
    t_reset();
    t_short(5, 1'b1);                       // R2, R5
    t_short(0, 1'b0);                       // R6, next byte is header
    t_short(SMAX, 1'b1);                    // R10 back to back, at limit
    t_err_short(SMAX + 1);                  // R7
    t_short(3, 1'b0);                       // header right after error
    t_long(5, 1'b1, 1'b0, 3'b111, 1'b0, 1'b1);
    t_long(LMAX, 1'b0, 1'b1, 3'b010, 1'b1, 1'b1); // R9 stalls
    t_long(0, 1'b1, 1'b1, 3'b101, 1'b0, 1'b1);
    t_err_long(LMAX + 1);
    t_long(257, 1'b1, 1'b1, 3'b001, 1'b0, 1'b0);  // R8 fmt low on byte1
    t_short(1, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule